// File: doc/BRIEF.md
# Passive I2C Bus Monitor Recorder

This block listens to the clock and data lines of an I2C or SMBus segment and never drives them. It turns what it sees into a stream of 16-bit record words. After reset, and after any protocol violation, it stays unsynchronized. It locks on only once the bus has sat idle, with both lines high and data unchanged, for a programmable number of cycles. Once locked, it decodes START and repeated START conditions, each nine-pulse byte slot (eight data bits plus the acknowledge bit) and STOP conditions. Each finished byte and each STOP produces one record.

Records leave through a valid/ready stream that a buffer writer consumes. A running record counter sits on its own output, so the writer or a mailbox can follow progress. Both line inputs are assumed to be already synchronized and deglitched. The block copies them into a single snapshot register each cycle, and every decision in a cycle uses that one snapshot. Timeouts are cycle counts, and their default values are derived from the clock frequency.

Top module: `i2c_bus_recorder`

## Requirements
- R1: During and after reset, rec_valid is 0, rec_count is 0 and overflow is 0.
- R2: Before synchronization, meaning SCL high and SDA high and unchanged for SYNC_CYC cycles, no bus activity produces a record. A START and a full byte seen before that leave rec_count unchanged.
- R3: A byte that follows a START gives a record with bit 11 = 1, bits 10:3 = the data byte (first bit on the wire in bit 10), bit 2 = the SDA level during the ninth pulse, and bits 15:12 and 1:0 = 0.
- R4: SDA rising while SCL is high, after an acknowledge bit, gives the record 16'h0001.
- R5: If SCL falls after the acknowledge bit with SDA steady, the level sampled in that pulse is the first bit of a further byte, and that byte's record has bit 11 = 0.
- R6: SDA falling while SCL is high after an acknowledge bit is a repeated START. No record is written for it, and the next byte's record has bit 11 = 1.
- R7: An SDA change while SCL is high inside a data or acknowledge bit is an error. The monitor drops the byte without a record and must resynchronize.
- R8: SCL held low for LOW_CYC cycles, counted from the START or from the byte start, is an error. No record is written.
- R9: SCL held high for HIGH_CYC cycles inside a bit is an error. No record is written.
- R10: When synchronized and idle, SCL falling while SDA is high sends the monitor back to unsynchronized. Activity that follows without a new idle period gives no record.
- R11: While rec_valid is 1 and rec_ready is 0, rec_valid and rec_data hold. A new record that arrives in that state is dropped and sets overflow, which then stays 1 until reset.
- R12: rec_count increments by one for every record produced, including dropped ones. A record becomes valid at the second rising clock edge after the SCL fall or SDA rise that completes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line |
| rec_data | output | 16 | Record word |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_count | output | CNT_W | Records produced since reset |
| overflow | output | 1 | Sticky record-lost flag |

## Verification
Every record is due exactly two rising edges after the line change that completes it: one edge loads the snapshot, and the next edge loads the output register while the state machine reacts to that snapshot. The bench changes the lines on falling clock edges and samples on falling edges. It checks that rec_valid is still low after one cycle and high after two, which pins the latency without a search loop. For cases where no record must appear, the bench compares rec_count with its own running total once the whole stimulus has been applied, so a record produced at any time during the sequence is caught. Handshake holding is checked by sampling the stalled output several cycles apart.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

   localparam int unsigned REC_W = 16;
   localparam logic [REC_W-1:0] STOP_REC = 16'h0001;

   typedef enum logic [2:0] {
      ST_UNSYNC_LO,
      ST_UNSYNC_HI,
      ST_IDLE,
      ST_BIT_LO,
      ST_BIT_HI,
      ST_CHAR_LO,
      ST_CHAR_HI
   } mon_state_e;

   // start flag in bit 11, data bits 10:3, ack level bit 2, flags 1:0 clear
   function automatic logic [REC_W-1:0] byte_rec(input logic start, input logic [8:0] slot);
      return {4'b0000, start, slot, 2'b00};
   endfunction

endpackage

// File: rtl/i2cmon_timer.sv
module i2cmon_timer #(
   parameter int unsigned MAX = 100,
   localparam int unsigned W = $clog2(MAX + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr)               cnt <= '0;
      else if (cnt != W'(MAX))    cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/i2cmon_recout.sv
module i2cmon_recout #(
   parameter int unsigned REC_W = 16,
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [REC_W-1:0] push_data,
   input  logic             ready,
   output logic [REC_W-1:0] data,
   output logic             valid,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data  <= '0;
         valid <= 1'b0;
         count <= '0;
         ovf   <= 1'b0;
      end else if (push) begin
         count <= count + 1'b1;
         if (valid && !ready) begin
            ovf <= 1'b1;
         end else begin
            data  <= push_data;
            valid <= 1'b1;
         end
      end else if (valid && ready) begin
         valid <= 1'b0;
      end
   end

endmodule

// File: rtl/i2c_bus_recorder.sv
module i2c_bus_recorder
   import i2cmon_pkg::*;
#(
   parameter int unsigned CLK_HZ   = 50_000_000,
   parameter int unsigned SYNC_CYC = CLK_HZ / 20_000,
   parameter int unsigned HIGH_CYC = CLK_HZ / 20_000,
   parameter int unsigned LOW_CYC  = CLK_HZ / 40,
   parameter int unsigned CNT_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic [15:0]      rec_data,
   output logic             rec_valid,
   input  logic             rec_ready,
   output logic [CNT_W-1:0] rec_count,
   output logic             overflow
);

   localparam int unsigned HI_MAX = (SYNC_CYC > HIGH_CYC) ? SYNC_CYC : HIGH_CYC;
   localparam int unsigned HI_W   = $clog2(HI_MAX + 1);
   localparam int unsigned LO_W   = $clog2(LOW_CYC + 1);

   generate
      if (SYNC_CYC < 2 || HIGH_CYC < 2) begin : g_bad_high
         $error("SYNC_CYC and HIGH_CYC must be at least 2");
      end
      if (LOW_CYC <= HIGH_CYC) begin : g_bad_low
         $error("LOW_CYC must exceed HIGH_CYC");
      end
      if (CNT_W < 1 || REC_W != 16) begin : g_bad_width
         $error("record counter or record width out of range");
      end
   endgenerate

   // one snapshot of both lines per cycle
   logic snap_scl, snap_sda, prev_sda;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_scl <= 1'b1;
         snap_sda <= 1'b1;
         prev_sda <= 1'b1;
      end else begin
         snap_scl <= scl_i;
         snap_sda <= sda_i;
         prev_sda <= snap_sda;
      end
   end

   logic            hi_clr, lo_clr;
   logic [HI_W-1:0] hi_cnt;
   logic [LO_W-1:0] lo_cnt;

   i2cmon_timer #(.MAX(HI_MAX)) u_hi_tmr (.clk(clk), .rst_n(rst_n), .clr(hi_clr), .cnt(hi_cnt));
   i2cmon_timer #(.MAX(LOW_CYC)) u_lo_tmr (.clk(clk), .rst_n(rst_n), .clr(lo_clr), .cnt(lo_cnt));

   wire sync_done = (hi_cnt >= HI_W'(SYNC_CYC));
   wire high_late = (hi_cnt >= HI_W'(HIGH_CYC));
   wire low_late  = (lo_cnt >= LO_W'(LOW_CYC));

   mon_state_e st, st_n;
   logic       lat, lat_n, sf, sf_n;
   logic [8:0] sh, sh_n;
   logic [3:0] bc, bc_n;
   logic       push, push_stop;
   logic [REC_W-1:0] push_data;

   always_comb begin
      st_n = st; lat_n = lat; sf_n = sf; sh_n = sh; bc_n = bc;
      hi_clr = 1'b0; lo_clr = 1'b0; push = 1'b0; push_stop = 1'b0;
      unique case (st)
         ST_UNSYNC_LO: begin
            hi_clr = 1'b1; lo_clr = 1'b1;
            if (snap_scl) st_n = ST_UNSYNC_HI;
         end
         ST_UNSYNC_HI: begin
            lo_clr = 1'b1;
            if (!snap_scl)                    st_n = ST_UNSYNC_LO;
            else if (snap_sda != prev_sda)    hi_clr = 1'b1;
            else if (snap_sda && sync_done)   st_n = ST_IDLE;
         end
         ST_IDLE: begin
            hi_clr = 1'b1; lo_clr = 1'b1;
            if (!snap_scl) begin
               if (snap_sda) begin
                  st_n = ST_UNSYNC_LO;
               end else begin
                  st_n = ST_BIT_LO; sf_n = 1'b1; bc_n = '0; sh_n = '0;
               end
            end
         end
         ST_BIT_LO: begin
            if (low_late) st_n = ST_UNSYNC_LO;
            else if (snap_scl) begin
               sh_n = {sh[7:0], snap_sda}; lat_n = snap_sda;
               hi_clr = 1'b1; st_n = ST_BIT_HI;
            end
         end
         ST_BIT_HI: begin
            if (high_late) st_n = ST_UNSYNC_LO;
            else if (!snap_scl) begin
               if (bc == 4'd8) begin
                  push = 1'b1; st_n = ST_CHAR_LO;
               end else begin
                  bc_n = bc + 1'b1; st_n = ST_BIT_LO;
               end
            end else if (snap_sda != lat) st_n = ST_UNSYNC_LO;
         end
         ST_CHAR_LO: begin
            if (low_late) st_n = ST_UNSYNC_LO;
            else if (snap_scl) begin
               lat_n = snap_sda; hi_clr = 1'b1; st_n = ST_CHAR_HI;
            end
         end
         ST_CHAR_HI: begin
            if (high_late) st_n = ST_UNSYNC_LO;
            else if (snap_scl && (snap_sda != lat)) begin
               push = snap_sda; push_stop = snap_sda; st_n = ST_IDLE;
            end else if (!snap_scl) begin
               sh_n = {8'h00, lat}; bc_n = 4'd1; sf_n = 1'b0;
               lo_clr = 1'b1; st_n = ST_BIT_LO;
            end
         end
         default: st_n = ST_UNSYNC_LO;
      endcase
   end

   assign push_data = push_stop ? STOP_REC : byte_rec(sf, sh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_UNSYNC_LO; lat <= 1'b0; sf <= 1'b0; sh <= '0; bc <= '0;
      end else begin
         st <= st_n; lat <= lat_n; sf <= sf_n; sh <= sh_n; bc <= bc_n;
      end
   end

   i2cmon_recout #(.REC_W(REC_W), .CNT_W(CNT_W)) u_out (
      .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
      .ready(rec_ready), .data(rec_data), .valid(rec_valid),
      .count(rec_count), .ovf(overflow)
   );

endmodule

// File: rtl/i2cmon_checker.sv
module i2cmon_checker #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [15:0]      rec_data,
   input logic             rec_valid,
   input logic             rec_ready,
   input logic [CNT_W-1:0] rec_count,
   input logic             overflow
);

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data)));

   a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   a_r11_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> $past(rec_valid && !rec_ready));

   a_r12_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_count != $past(rec_count)) |-> (rec_count == $past(rec_count) + 1'b1));

   a_r12_valid_counted: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rec_valid) |-> (rec_count != $past(rec_count)));

   a_r3_format: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> ((rec_data == 16'h0001) ||
                     (rec_data[15:12] == 4'h0 && rec_data[1:0] == 2'b00)));

endmodule

bind i2c_bus_recorder i2cmon_checker #(.CNT_W(CNT_W)) u_i2cmon_checker (
   .clk(clk), .rst_n(rst_n), .rec_data(rec_data), .rec_valid(rec_valid),
   .rec_ready(rec_ready), .rec_count(rec_count), .overflow(overflow)
);

// File: tb/test_i2c_bus_recorder.sv
module test_i2c_bus_recorder;

   localparam int SYNC = 20;
   localparam int HIGH = 20;
   localparam int LOW  = 200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1, sda = 1'b1, ready = 1'b1;
   logic [15:0] rec_data;
   logic        rec_valid, overflow;
   logic [15:0] rec_count;

   int n_chk = 0, n_fail = 0, exp_cnt = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   i2c_bus_recorder #(.SYNC_CYC(SYNC), .HIGH_CYC(HIGH), .LOW_CYC(LOW), .CNT_W(16)) i_i2c_bus_recorder (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
      .rec_data(rec_data), .rec_valid(rec_valid), .rec_ready(ready),
      .rec_count(rec_count), .overflow(overflow)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic w(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic b, input int hi, input int post);
      sda = b; w(2); scl = 1'b1; w(hi); scl = 1'b0; w(post);
   endtask

   task automatic glitch_pulse(input logic b);
      sda = b; w(2); scl = 1'b1; w(2); sda = ~b; w(2); scl = 1'b0; w(2);
   endtask

   task automatic go_idle_sync();
      scl = 1'b1; sda = 1'b1; w(SYNC + 10);
   endtask

   task automatic start_cond();
      sda = 1'b0; w(4); scl = 1'b0; w(2);
   endtask

   task automatic send_bits(input logic [7:0] d, input int first);
      for (int i = first; i >= 0; i--) pulse(d[i], 4, 2);
   endtask

   task automatic stop_cond();
      sda = 1'b0; w(2); scl = 1'b1; w(4); sda = 1'b1; w(2);
   endtask

   task automatic expect_rec(input logic [15:0] exp, input string req);
      exp_cnt++;
      chk(rec_valid === 1'b1, req, 32'(rec_valid), 32'h1);
      chk(rec_data === exp, req, 32'(rec_data), 32'(exp));
      chk(rec_count === 16'(exp_cnt), req, 32'(rec_count), 32'(exp_cnt));
   endtask

   task automatic t_reset();
      chk(rec_valid === 1'b0 && overflow === 1'b0 && rec_count === 16'd0, "R1 in reset",
          {rec_count, 14'b0, rec_valid, overflow}, 32'h0);
      w(2); rst_n = 1'b1; w(1);
      chk(rec_valid === 1'b0 && overflow === 1'b0 && rec_count === 16'd0, "R1 after reset",
          {rec_count, 14'b0, rec_valid, overflow}, 32'h0);
   endtask

   task automatic t_nosync();
      w(3); start_cond(); send_bits(8'hA5, 7); pulse(1'b0, 4, 2);
      stop_cond(); w(4);
      chk(rec_count === 16'(exp_cnt), "R2 no record before sync", 32'(rec_count), 32'(exp_cnt));
   endtask

   task automatic t_byte_stop();
      go_idle_sync(); start_cond(); send_bits(8'hA5, 7);
      pulse(1'b0, 4, 1);
      chk(rec_valid === 1'b0, "R12 not yet valid one cycle after", 32'(rec_valid), 32'h0);
      w(1);
      expect_rec(16'h0D28, "R3 start byte A5 ack0");
      send_bits(8'h3C, 7); pulse(1'b1, 4, 2);
      expect_rec(16'h01E4, "R5 continued byte 3C nak");
      stop_cond();
      expect_rec(16'h0001, "R4 stop record");
      w(4);
   endtask

   task automatic t_rstart();
      start_cond(); send_bits(8'h91, 7); pulse(1'b0, 4, 2);
      expect_rec(16'h0C88, "R6 first byte 91");
      sda = 1'b1; w(2); scl = 1'b1; w(4); sda = 1'b0; w(2);
      chk(rec_valid === 1'b0 && rec_count === 16'(exp_cnt), "R6 no record for repeated start",
          32'(rec_count), 32'(exp_cnt));
      w(2); scl = 1'b0; w(2);
      send_bits(8'h42, 7); pulse(1'b1, 4, 2);
      expect_rec(16'h0A14, "R6 byte after repeated start");
      stop_cond();
      expect_rec(16'h0001, "R6 closing stop");
      w(4);
   endtask

   task automatic t_sda_err();
      go_idle_sync(); start_cond(); send_bits(8'hA0, 7);
      glitch_pulse(1'b1);
      send_bits(8'h55, 7); pulse(1'b0, 4, 2); stop_cond(); w(4);
      chk(rec_count === 16'(exp_cnt), "R7 sda change in bit drops byte", 32'(rec_count), 32'(exp_cnt));
   endtask

   task automatic t_low_to();
      go_idle_sync(); start_cond(); w(LOW + 20);
      send_bits(8'h66, 7); pulse(1'b0, 4, 2); w(4);
      chk(rec_count === 16'(exp_cnt), "R8 scl low timeout", 32'(rec_count), 32'(exp_cnt));
   endtask

   task automatic t_high_to();
      go_idle_sync(); start_cond();
      pulse(1'b0, HIGH + 10, 2);
      send_bits(8'h12, 6); pulse(1'b0, 4, 2); w(4);
      chk(rec_count === 16'(exp_cnt), "R9 scl high timeout", 32'(rec_count), 32'(exp_cnt));
   endtask

   task automatic t_idle_fall();
      go_idle_sync();
      scl = 1'b0; w(4); scl = 1'b1; w(4);
      start_cond(); send_bits(8'h77, 7); pulse(1'b0, 4, 2); w(4);
      chk(rec_count === 16'(exp_cnt), "R10 scl fall with sda high unsyncs", 32'(rec_count), 32'(exp_cnt));
   endtask

   task automatic t_backpressure();
      go_idle_sync(); ready = 1'b0;
      start_cond(); send_bits(8'h5A, 7); pulse(1'b0, 4, 2);
      expect_rec(16'h0AD0, "R11 first record");
      w(10);
      chk(rec_valid === 1'b1 && rec_data === 16'h0AD0, "R11 held under stall",
          32'(rec_data), 32'h0AD0);
      chk(overflow === 1'b0, "R11 no overflow yet", 32'(overflow), 32'h0);
      stop_cond(); exp_cnt++;
      chk(overflow === 1'b1, "R11 overflow on dropped record", 32'(overflow), 32'h1);
      chk(rec_data === 16'h0AD0, "R11 pending record kept", 32'(rec_data), 32'h0AD0);
      chk(rec_count === 16'(exp_cnt), "R12 dropped record counted", 32'(rec_count), 32'(exp_cnt));
      ready = 1'b1; w(1);
      chk(rec_valid === 1'b0, "R11 valid drops after accept", 32'(rec_valid), 32'h0);
      w(5);
      chk(overflow === 1'b1, "R11 overflow sticky", 32'(overflow), 32'h1);
   endtask

   initial begin
      w(1);
      t_reset();
      t_nosync();
      t_byte_stop();
      t_rstart();
      t_sda_err();
      t_low_to();
      t_high_to();
      t_idle_fall();
      t_backpressure();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule